// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block carries out one command transaction on a small-page NAND flash device across an 8- or 16-bit parallel bus. A transaction is the opcode, then an optional column address, then an optional page address. The caller presents these with a chip-size flag and a bus-width flag, and pulses `start`. The sequencer latches everything on that edge. It then strobes each command or address byte with its own write-enable pulse. It raises the command latch for opcodes and the address latch for address bytes.

A sequential-data-input (program setup) opcode is always preceded by a pointer opcode. The sequencer chooses that pointer from the column region and rebases the column to match. After the address phase the sequencer acts by command class:

- Program, erase and status opcodes finish at once.
- Every other opcode waits a short fixed settle time and then polls a ready bit.
- Read opcodes bound that poll with a chip-delay limit and report a timeout when it expires.
- A read that carries a page address holds chip enable low from its address phase until the wait ends.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset and while idle: `nce`=1, `nwe`=1, `cle`=0, `ale`=0, `dq_oe`=0, `dq_out`=0, `busy`=0, `done`=0, `timeout`=0.
- R2: Each byte is strobed by `nwe` low for WE_LO cycles and then high for WE_HI cycles. During the strobe `dq_out` carries the byte in bits 7:0 with the upper bits zero, `dq_oe`=1 and `nce`=0. `cle`=1 for opcode bytes and `ale`=1 for address bytes. The first byte starts in the cycle after the `start` edge.
- R3: Opcode 0x80 is preceded by one pointer opcode. If column >= PAGE_BYTES (512), the pointer is 0x50 and the column has 512 subtracted. If column < 256, the pointer is 0x00. Otherwise the pointer is 0x01 and the column has 256 subtracted.
- R4: Address bytes follow the opcode in this order: column byte if `col_valid`, then page bits 7:0 and page bits 15:8 if `page_valid`. With neither flag set, no address byte is sent.
- R5: With `large_dev`=1 and a page present, a further address byte follows carrying page bits 19:16 in its low nibble and zeros in its high nibble.
- R6: With `bus16`=1, the column (after any R3 rebasing) is shifted right by one before its low 8 bits are sent.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 finish without waiting: `done` is high in the cycle after the last byte's strobe.
- R8: All other opcodes idle for TWB cycles (ceil(CLK_MHZ*TWB_NS/1000)) after the last strobe and then poll `dev_stat[0]` (1 = ready) once per cycle. They finish in the cycle after ready is seen. `dev_stat[7:1]` has no effect.
- R9: For read opcodes 0x00, 0x01 and 0x50, the poll lasts at most CLK_MHZ*CHIP_US cycles. If ready is never seen, `done` and `timeout` pulse together. Other opcodes poll with no limit and never raise `timeout`.
- R10: A read opcode with a page address keeps `nce`=0 from its first strobe through the whole wait, releasing it with `done`. Any other waiting command leaves `nce`=1 during the wait.
- R11: `busy` is 1 from the cycle after an accepted `start` until the transaction ends. `done` is a one-cycle pulse with `busy`=0. A `start` while busy is ignored, and the inputs are only sampled when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| cmd | input | 8 | Opcode |
| col_valid | input | 1 | Column address present |
| col | input | COL_W | Column address in bytes |
| page_valid | input | 1 | Page address present |
| page | input | PAGE_W | Page address |
| large_dev | input | 1 | Device above 32 MiB: extra page byte |
| bus16 | input | 1 | 16-bit bus: column counts words |
| dev_stat | input | 8 | Device status; bit 0 is ready |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write enable, active low |
| dq_out | output | DQ_W | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (pulse) |
| timeout | output | 1 | Read wait expired (pulse with done) |

## Verification
The bench covers the program setup opcode with three columns: one in the low half, one in the high half and one in the spare area. These show that the pointer choice and the rebasing are separate. One of them is repeated on a wide bus with a large device, which shows that halving happens after rebasing and that the extra page nibble is sent.

Reads are run in three ways: ready arriving late, ready already present when polling starts, and ready never arriving. These show the exact poll start, the chip-enable hold and the timeout bound. A reset opcode with ready arriving long after the read limit shows that only reads are bounded.

Status bits other than bit 0 are held high throughout. A second `start` with a different opcode is pulsed in the middle of a read. Every output is compared on every cycle against a model built from the requirements.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int FRAME_N = 8;
  localparam int IDX_W   = $clog2(FRAME_N);

  localparam logic [7:0] OP_RD_LO  = 8'h00;
  localparam logic [7:0] OP_RD_HI  = 8'h01;
  localparam logic [7:0] OP_RD_SPR = 8'h50;
  localparam logic [7:0] OP_SEQIN  = 8'h80;
  localparam logic [7:0] OP_PROG   = 8'h10;
  localparam logic [7:0] OP_ERS1   = 8'h60;
  localparam logic [7:0] OP_ERS2   = 8'hD0;
  localparam logic [7:0] OP_STAT   = 8'h70;

  typedef enum logic [1:0] {BK_NONE, BK_CMD, BK_ADDR} byte_kind_t;

  typedef struct packed {
    byte_kind_t  kind;
    logic [7:0]  val;
  } bus_byte_t;

  typedef enum logic [1:0] {WC_NONE, WC_BOUNDED, WC_OPEN} wait_cls_t;

  // pointer opcode that must precede sequential data input
  function automatic logic [7:0] seq_ptr(input logic [15:0] c, input int pb);
    if (int'(c) >= pb)       return OP_RD_SPR;
    else if (c >= 16'd256)   return OP_RD_HI;
    else                     return OP_RD_LO;
  endfunction

  // column rebased into the region selected by seq_ptr
  function automatic logic [15:0] col_rebase(input logic [15:0] c, input int pb);
    if (int'(c) >= pb)       return c - 16'(pb);
    else if (c >= 16'd256)   return c - 16'd256;
    else                     return c;
  endfunction

  // column byte placed on the bus; wide bus counts words
  function automatic logic [7:0] col_lane(input logic [15:0] c, input logic wide);
    logic [15:0] t;
    t = wide ? (c >> 1) : c;
    return t[7:0];
  endfunction

  function automatic wait_cls_t classify(input logic [7:0] op);
    case (op)
      OP_PROG, OP_ERS1, OP_ERS2, OP_SEQIN, OP_STAT: return WC_NONE;
      OP_RD_LO, OP_RD_HI, OP_RD_SPR:                return WC_BOUNDED;
      default:                                      return WC_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/nand_seq_frame.sv
module nand_seq_frame
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_BYTES = 512
)(
  input  logic [7:0]                    cmd,
  input  logic                          col_valid,
  input  logic [COL_W-1:0]              col,
  input  logic                          page_valid,
  input  logic [19:0]                   page,
  input  logic                          large_dev,
  input  logic                          bus16,
  output bus_byte_t [FRAME_N-1:0]       frame,
  output logic [IDX_W-1:0]              nbytes,
  output logic [IDX_W-1:0]              pg_idx,
  output wait_cls_t                     cls,
  output logic                          hold_ce
);

  logic [15:0]      colx;
  logic [IDX_W-1:0] n;

  always_comb begin
    frame  = '0;
    n      = '0;
    colx   = 16'(col);
    pg_idx = '0;
    if (cmd == OP_SEQIN) begin
      frame[n] = '{kind: BK_CMD, val: seq_ptr(colx, PAGE_BYTES)};
      colx     = col_rebase(colx, PAGE_BYTES);
      n        = n + 1'b1;
    end
    frame[n] = '{kind: BK_CMD, val: cmd};
    n        = n + 1'b1;
    if (col_valid) begin
      frame[n] = '{kind: BK_ADDR, val: col_lane(colx, bus16)};
      n        = n + 1'b1;
    end
    pg_idx = n;
    if (page_valid) begin
      frame[n] = '{kind: BK_ADDR, val: page[7:0]};
      n        = n + 1'b1;
      frame[n] = '{kind: BK_ADDR, val: page[15:8]};
      n        = n + 1'b1;
      if (large_dev) begin
        frame[n] = '{kind: BK_ADDR, val: {4'h0, page[19:16]}};
        n        = n + 1'b1;
      end
    end
    nbytes = n;
  end

  assign cls     = classify(cmd);
  assign hold_ce = (cls == WC_BOUNDED) && page_valid;

endmodule

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
  parameter int WE_LO = 2,
  parameter int WE_HI = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic we_low,
  output logic byte_end
);

  localparam int MAXC = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int CW   = $clog2(MAXC + 1);

  logic          lo_q;
  logic [CW-1:0] cnt_q;

  assign we_low   = run && lo_q;
  assign byte_end = run && !lo_q && (cnt_q == CW'(WE_HI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!run) begin
      lo_q  <= 1'b1;
      cnt_q <= '0;
    end else if (lo_q) begin
      if (cnt_q == CW'(WE_LO - 1)) begin
        lo_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (byte_end) begin
      lo_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/nand_rdy_wait.sv
module nand_rdy_wait #(
  parameter int TWB_CYC = 13,
  parameter int TO_CYC  = 3750
)(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bounded,
  input  logic rdy,
  output logic fin,
  output logic expired
);

  localparam int MAXV = (TWB_CYC > TO_CYC) ? TWB_CYC : TO_CYC;
  localparam int CW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {W_IDLE, W_TWB, W_POLL} wst_t;

  wst_t          st_q;
  logic [CW-1:0] cnt_q;
  logic          limit_hit;

  assign limit_hit = bounded && (cnt_q == CW'(TO_CYC - 1));
  assign fin       = (st_q == W_POLL) && (rdy || limit_hit);
  assign expired   = (st_q == W_POLL) && !rdy && limit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (arm) begin
          st_q  <= W_TWB;
          cnt_q <= '0;
        end
        W_TWB: if (cnt_q == CW'(TWB_CYC - 1)) begin
          st_q  <= W_POLL;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        W_POLL: if (fin) begin
          st_q  <= W_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R8
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (st_q == W_IDLE));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20,
  parameter int DQ_W       = 16,
  parameter int PAGE_BYTES = 512,
  parameter int CLK_MHZ    = 125,
  parameter int CHIP_US    = 30,
  parameter int TWB_NS     = 100,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cmd,
  input  logic              col_valid,
  input  logic [COL_W-1:0]  col,
  input  logic              page_valid,
  input  logic [PAGE_W-1:0] page,
  input  logic              large_dev,
  input  logic              bus16,
  input  logic [7:0]        dev_stat,
  output logic              cle,
  output logic              ale,
  output logic              nce,
  output logic              nwe,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              done,
  output logic              timeout
);

  localparam int TWB_RAW = (CLK_MHZ * TWB_NS + 999) / 1000;
  localparam int TWB_CYC = (TWB_RAW < 1) ? 1 : TWB_RAW;
  localparam int TO_CYC  = CLK_MHZ * CHIP_US;

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_WAIT} tst_t;

  // frame builder outputs
  bus_byte_t [FRAME_N-1:0] frm_c;
  logic [IDX_W-1:0]        nbytes_c, pgidx_c;
  wait_cls_t               cls_c;
  logic                    hold_c;

  // latched transaction
  bus_byte_t [FRAME_N-1:0] frm_q;
  logic [IDX_W-1:0]        nbytes_q, pgidx_q, idx_q;
  wait_cls_t               cls_q;
  logic                    hold_q;
  tst_t                    st_q;
  logic                    force_q, done_q, to_q;

  // named internal events
  logic      sending, we_low, byte_end, last_byte, arm, wait_fin, wait_expired;
  bus_byte_t cur;
  logic      stat_unused;

  assign stat_unused = ^dev_stat[7:1];

  nand_seq_frame #(.COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES)) u_frame (
    .cmd        (cmd),
    .col_valid  (col_valid),
    .col        (col),
    .page_valid (page_valid),
    .page       (20'(page)),
    .large_dev  (large_dev),
    .bus16      (bus16),
    .frame      (frm_c),
    .nbytes     (nbytes_c),
    .pg_idx     (pgidx_c),
    .cls        (cls_c),
    .hold_ce    (hold_c)
  );

  assign sending   = (st_q == T_SEND);
  assign cur       = frm_q[idx_q];
  assign last_byte = (idx_q == nbytes_q - 1'b1);
  assign arm       = sending && byte_end && last_byte && (cls_q != WC_NONE);

  nand_we_timer #(.WE_LO(WE_LO), .WE_HI(WE_HI)) u_we (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sending),
    .we_low   (we_low),
    .byte_end (byte_end)
  );

  nand_rdy_wait #(.TWB_CYC(TWB_CYC), .TO_CYC(TO_CYC)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .bounded (cls_q == WC_BOUNDED),
    .rdy     (dev_stat[0]),
    .fin     (wait_fin),
    .expired (wait_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= T_IDLE;
      frm_q    <= '0;
      nbytes_q <= '0;
      pgidx_q  <= '0;
      idx_q    <= '0;
      cls_q    <= WC_NONE;
      hold_q   <= 1'b0;
      force_q  <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      case (st_q)
        T_IDLE: if (start) begin
          frm_q    <= frm_c;
          nbytes_q <= nbytes_c;
          pgidx_q  <= pgidx_c;
          cls_q    <= cls_c;
          hold_q   <= hold_c;
          idx_q    <= '0;
          st_q     <= T_SEND;
        end
        T_SEND: if (byte_end) begin
          if (hold_q && (idx_q == pgidx_q)) force_q <= 1'b1;
          if (last_byte) begin
            if (cls_q == WC_NONE) begin
              st_q   <= T_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= T_WAIT;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        T_WAIT: if (wait_fin) begin
          st_q    <= T_IDLE;
          done_q  <= 1'b1;
          to_q    <= wait_expired;
          force_q <= 1'b0;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign cle     = sending && (cur.kind == BK_CMD);
  assign ale     = sending && (cur.kind == BK_ADDR);
  assign nwe     = !we_low;
  assign dq_out  = sending ? DQ_W'(cur.val) : '0;
  assign dq_oe   = sending;
  assign nce     = !(sending || force_q);
  assign busy    = (st_q != T_IDLE);
  assign done    = done_q;
  assign timeout = to_q;

  // R11
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R2
  strobe_has_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nwe) |-> (cle || ale));

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !busy));

  // R10
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_q) |-> done);

endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;

  localparam int LO  = 2;
  localparam int HI  = 1;
  localparam int MHZ = 125;
  localparam int US  = 1;
  localparam int TWB = 13;
  localparam int TO  = MHZ * US;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd = '0;
  logic        col_valid = 1'b0;
  logic [9:0]  col = '0;
  logic        page_valid = 1'b0;
  logic [19:0] page = '0;
  logic        large_dev = 1'b0;
  logic        bus16 = 1'b0;
  logic [7:0]  dev_stat = 8'hFE;
  logic        cle, ale, nce, nwe, dq_oe, busy, done, timeout;
  logic [15:0] dq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nand_cmd_seq #(.WE_LO(LO), .WE_HI(HI), .CLK_MHZ(MHZ), .CHIP_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .col_valid(col_valid), .col(col), .page_valid(page_valid), .page(page),
    .large_dev(large_dev), .bus16(bus16), .dev_stat(dev_stat),
    .cle(cle), .ale(ale), .nce(nce), .nwe(nwe), .dq_out(dq_out),
    .dq_oe(dq_oe), .busy(busy), .done(done), .timeout(timeout)
  );

  function automatic logic [23:0] pack(bit c, bit a, bit ce, bit we, bit oe,
                                       bit b, bit d, bit t, int dq);
    return {c, a, ce, we, oe, b, d, t, 16'(dq)};
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp, int cyc);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h (cle,ale,nce,nwe,oe,busy,done,to,dq)",
               req, cyc, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input bit cv, input int cl,
                     input bit pv, input int pg, input bit lg, input bit w16,
                     input int rdy_at, input bit inject, input string req);
    int  bv[$];
    bit  bk[$];
    int  cw, s, p, ce, i, ph;
    bit  to_exp, hold, is_rd, nowait;
    logic [23:0] exp, act;
    string tag;
    cw = cl;
    if (op == 8'h80) begin
      if (cl >= 512)      begin bv.push_back(8'h50); cw = cl - 512; end
      else if (cl >= 256) begin bv.push_back(8'h01); cw = cl - 256; end
      else                bv.push_back(8'h00);
      bk.push_back(1'b1);
    end
    bv.push_back(int'(op)); bk.push_back(1'b1);
    if (cv) begin
      if (w16) cw = cw / 2;
      bv.push_back(cw % 256); bk.push_back(1'b0);
    end
    if (pv) begin
      bv.push_back(pg % 256);           bk.push_back(1'b0);
      bv.push_back((pg / 256) % 256);   bk.push_back(1'b0);
      if (lg) begin bv.push_back((pg / 65536) % 16); bk.push_back(1'b0); end
    end
    is_rd  = (op == 8'h00) || (op == 8'h01) || (op == 8'h50);
    nowait = (op == 8'h10) || (op == 8'h60) || (op == 8'hD0) ||
             (op == 8'h80) || (op == 8'h70);
    hold   = is_rd && pv;
    s      = bv.size() * (LO + HI);
    to_exp = 1'b0;
    if (nowait) ce = s;
    else begin
      p  = s + TWB + 1;
      ce = (rdy_at > p) ? rdy_at : p;
      if (is_rd && (ce - p >= TO)) begin ce = p + TO - 1; to_exp = 1'b1; end
    end

    @(negedge clk);
    cmd = op; col_valid = cv; col = 10'(cl); page_valid = pv; page = 20'(pg);
    large_dev = lg; bus16 = w16; dev_stat = 8'hFE; start = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= ce + 2; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      if (c <= s) begin
        i   = (c - 1) / (LO + HI);
        ph  = (c - 1) % (LO + HI);
        exp = pack(bk[i], !bk[i], 1'b0, ph >= LO, 1'b1, 1'b1, 1'b0, 1'b0, bv[i]);
        tag = {req, " R2"};
      end else if (c <= ce) begin
        exp = pack(0, 0, !hold, 1, 0, 1, 0, 0, 0);
        tag = {req, " R8"};
      end else if (c == ce + 1) begin
        exp = pack(0, 0, 1, 1, 0, 0, 1, to_exp, 0);
        tag = {req, " R11"};
      end else begin
        exp = pack(0, 0, 1, 1, 0, 0, 0, 0, 0);
        tag = {req, " R11"};
      end
      act = {cle, ale, nce, nwe, dq_oe, busy, done, timeout, dq_out};
      chk(tag, act, exp, c);
      if (c >= rdy_at) dev_stat[0] = 1'b1;
      // R11: start pulsed with another opcode while busy must be ignored
      if (inject && c == 3) begin start = 1'b1; cmd = 8'h70; col = '0; end
      if (inject && c == 4) start = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", {cle, ale, nce, nwe, dq_oe, busy, done, timeout, dq_out},
        pack(0, 0, 1, 1, 0, 0, 0, 0, 0), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {cle, ale, nce, nwe, dq_oe, busy, done, timeout, dq_out},
        pack(0, 0, 1, 1, 0, 0, 0, 0, 0), 0);

    // R3 R4 R7: low-half pointer, column and page bytes, no wait
    run(8'h80, 1, 10,  1, 'h01234, 0, 0, 0, 0, "R3 R4 R7");
    // R3: high-half pointer, column rebased by 256
    run(8'h80, 1, 300, 1, 'h00567, 0, 0, 0, 0, "R3");
    // R3: spare pointer, column rebased by 512
    run(8'h80, 1, 520, 1, 'h00001, 0, 0, 0, 0, "R3");
    // R5 R6: rebased then halved, extra nibble byte
    run(8'h80, 1, 300, 1, 'hABCDE, 1, 1, 0, 0, "R3 R5 R6");
    // R8 R10 R11: read, late ready, chip enable held, stray start
    run(8'h00, 1, 5,   1, 'h00042, 0, 0, 40, 1, "R8 R10 R11");
    // R9 R10: spare read never ready, timeout
    run(8'h50, 1, 3,   1, 'h00099, 0, 0, 100000, 0, "R9 R10");
    // R4 R8: opcode only, open wait, chip enable released
    run(8'hFF, 0, 0,   0, 0,       0, 0, 30, 0, "R4 R8");
    // R9: open wait longer than read bound, no timeout
    run(8'hFF, 0, 0,   0, 0,       0, 0, 217, 0, "R9");
    // R7: status, no wait
    run(8'h70, 0, 0,   0, 0,       0, 0, 0, 0, "R7");
    // R4 R5 R7: erase setup with page only, large device
    run(8'h60, 0, 0,   1, 'hFEDCB, 1, 0, 0, 0, "R4 R5 R7");
    // R6 R8 R10: read on wide bus, ready already present at first poll
    run(8'h01, 1, 7,   1, 'h00321, 0, 1, 5, 0, "R6 R8 R10");
    // R7: program confirm
    run(8'h10, 0, 0,   0, 0,       0, 0, 0, 0, "R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule